// File: doc/BRIEF.md
# PS/2 Keyboard Held-Key Decoder

This block receives the keyboard-to-host serial stream of a PS/2 keyboard on its clock and data lines and brings both lines into the system clock domain. It frames each packet and decodes the scan codes. A processor polls one 8-bit register. That register holds the ASCII code of the key currently held down, or 0x00 once that key has been let go. Raw scan codes are not queued.

The decoder remembers a pending release prefix and the state of both shift keys and the control key. It translates a small set of scan codes through a computed table: letters, digits, space, enter, backspace, comma, period and minus. Shift turns letters into capitals. Control turns letters into control codes. A one-cycle strobe marks each new translated key press, so an interrupt-driven host does not have to poll.

Top module: `ps2_key_decoder`

## Requirements
- R1: After reset the key register reads 0x00 and the new-key strobe is low.
- R2: A frame has 11 bits: a 0 start bit, eight data bits least significant first, parity, and stop. Bits are taken on the falling edge of the keyboard clock. The scan code 0x1C sets the key register to 0x61.
- R3: Each translated make code raises the new-key strobe for exactly one system cycle, and the key register is nonzero while it is high.
- R4: The code 0xF0 followed by any table code clears the key register to 0x00 and raises no strobe.
- R5: While left shift (0x12) or right shift (0x59) is held, letters translate to upper case (0x1C gives 0x41). Releasing the shift key restores lower case.
- R6: While control (0x14) is held, a letter translates to its lower-case ASCII value ANDed with 0x1F (0x21 gives 0x03).
- R7: A scan code outside the table leaves the key register unchanged and raises no strobe.
- R8: A falling keyboard clock edge while idle with data high does not start a frame.
- R9: If the keyboard clock stays high for TIMEOUT_CYC system cycles in the middle of a frame, the bit count restarts and the next frame decodes normally.
- R10: Digits translate to ASCII whatever the shift state (0x16 gives 0x31), and enter (0x5A) gives 0x0D.
- R11: The translated key appears after the eighth data bit, before the parity bit's falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk_i | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_i | input | 1 | Keyboard data line, asynchronous |
| key_code_o | output | 8 | ASCII of the held key, 0x00 when none |
| key_new_o | output | 1 | One-cycle strobe on each translated key press |

## Verification
The assertions assume that the keyboard clock is much slower than the system clock, so each high or low phase lasts many system cycles. They also assume that data is stable across each falling clock edge and that only one byte is ever in flight. The stimulus drives every keyboard line change on the falling system clock edge. Each clock phase lasts forty system cycles, and data changes only while the keyboard clock is high. The single deliberate break in that pattern is a frame stalled in the middle with the clock held high past the timeout.

// File: rtl/ps2kd_pkg.sv
// Package: shared types and the scan-code translation function.
// Assumes scan code set 2 and covers only letters, digits and a few symbols.
package ps2kd_pkg;

    localparam logic [7:0] SC_BREAK  = 8'hF0;
    localparam logic [7:0] SC_LSHIFT = 8'h12;
    localparam logic [7:0] SC_RSHIFT = 8'h59;
    localparam logic [7:0] SC_CTRL   = 8'h14;

    typedef struct packed {
        logic       hit;
        logic       letter;
        logic [7:0] ascii;
    } xlat_t;

    // Map a make code to lower-case ASCII; hit=0 when not in the table.
    function automatic xlat_t scan_lookup(input logic [7:0] sc);
        xlat_t r;
        r.hit    = 1'b1;
        r.letter = 1'b1;
        r.ascii  = 8'h00;
        case (sc)
            8'h1C: r.ascii = "a";  8'h32: r.ascii = "b";
            8'h21: r.ascii = "c";  8'h23: r.ascii = "d";
            8'h24: r.ascii = "e";  8'h2B: r.ascii = "f";
            8'h34: r.ascii = "g";  8'h33: r.ascii = "h";
            8'h43: r.ascii = "i";  8'h3B: r.ascii = "j";
            8'h42: r.ascii = "k";  8'h4B: r.ascii = "l";
            8'h3A: r.ascii = "m";  8'h31: r.ascii = "n";
            8'h44: r.ascii = "o";  8'h4D: r.ascii = "p";
            8'h15: r.ascii = "q";  8'h2D: r.ascii = "r";
            8'h1B: r.ascii = "s";  8'h2C: r.ascii = "t";
            8'h3C: r.ascii = "u";  8'h2A: r.ascii = "v";
            8'h1D: r.ascii = "w";  8'h22: r.ascii = "x";
            8'h35: r.ascii = "y";  8'h1A: r.ascii = "z";
            default: begin
                r.letter = 1'b0;
                case (sc)
                    8'h45: r.ascii = "0";  8'h16: r.ascii = "1";
                    8'h1E: r.ascii = "2";  8'h26: r.ascii = "3";
                    8'h25: r.ascii = "4";  8'h2E: r.ascii = "5";
                    8'h36: r.ascii = "6";  8'h3D: r.ascii = "7";
                    8'h3E: r.ascii = "8";  8'h46: r.ascii = "9";
                    8'h29: r.ascii = 8'h20;
                    8'h5A: r.ascii = 8'h0D;
                    8'h66: r.ascii = 8'h08;
                    8'h41: r.ascii = ",";
                    8'h49: r.ascii = ".";
                    8'h4E: r.ascii = "-";
                    default: r.hit = 1'b0;
                endcase
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ps2kd_sync.sv
// Module: ps2kd_sync
// Brings the keyboard clock and data lines into the system domain through a
// STAGES-deep flop chain per line and flags falling edges of the clock.
// Assumes the keyboard lines idle high and change slowly against clk.
module ps2kd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ps2_clk_i,
    input  logic ps2_dat_i,
    output logic clk_s_o,
    output logic dat_s_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] clk_chain;
    logic [LAST:0] dat_chain;
    logic          clk_prev;

    // Shift each raw line through its synchronizer chain; idle high at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_chain <= '1;
            dat_chain <= '1;
        end else begin
            clk_chain[0] <= ps2_clk_i;
            dat_chain[0] <= ps2_dat_i;
            for (int i = 1; i < STAGES; i++) begin
                clk_chain[i] <= clk_chain[i-1];
                dat_chain[i] <= dat_chain[i-1];
            end
        end
    end

    // Remember the last synchronized clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_prev <= 1'b1;
        else        clk_prev <= clk_chain[LAST];
    end

    assign clk_s_o = clk_chain[LAST];
    assign dat_s_o = dat_chain[LAST];
    assign fall_o  = clk_prev & ~clk_chain[LAST];

endmodule

// File: rtl/ps2kd_framer.sv
// Module: ps2kd_framer
// Counts the bits of one 11-bit frame, assembles data LSB first and hands
// the byte on right after the eighth data bit. Parity is not checked.
// Assumes synchronized inputs and a one-cycle fall strobe.
module ps2kd_framer #(
    parameter int TIMEOUT_CYC = 12500,
    parameter int DATA_BITS   = 8,
    parameter int FRAME_BITS  = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clk_s_i,
    input  logic                 dat_s_i,
    input  logic                 fall_i,
    output logic                 byte_vld_o,
    output logic [DATA_BITS-1:0] byte_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam int TMR_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_BITS);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [TMR_W-1:0] TMR_END   = TMR_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0]     bit_cnt;
    logic [TMR_W-1:0]     tmr;
    logic [DATA_BITS-1:0] shreg;
    logic                 vld_q;

    // Advance the bit position on each falling edge, or drop a stalled frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            tmr     <= '0;
            shreg   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (fall_i) begin
                tmr <= '0;
                if (bit_cnt == '0) begin
                    if (!dat_s_i) bit_cnt <= 1;
                end else if (bit_cnt <= LAST_DATA) begin
                    shreg   <= {dat_s_i, shreg[DATA_BITS-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_DATA) vld_q <= 1'b1;
                end else if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (bit_cnt != '0 && clk_s_i) begin
                if (tmr == TMR_END) begin
                    bit_cnt <= '0;
                    tmr     <= '0;
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end else begin
                tmr <= '0;
            end
        end
    end

    assign byte_vld_o = vld_q;
    assign byte_o     = shreg;

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= LAST_BIT);
    assert_vld_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |=> !vld_q);
    assert_timeout_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_i && clk_s_i && bit_cnt != '0 && tmr == TMR_END) |=> bit_cnt == '0);
    assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && dat_s_i && bit_cnt == '0) |=> bit_cnt == '0);

endmodule

// File: rtl/ps2kd_keystate.sv
// Module: ps2kd_keystate
// Tracks the release prefix and modifier flags, translates make codes and
// keeps the held-key register plus a one-cycle new-key strobe.
// Assumes byte_vld_i pulses for one cycle per received byte.
module ps2kd_keystate
    import ps2kd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    output logic [7:0] key_o,
    output logic       new_o
);
    logic       brk_q;
    logic       lsh_q;
    logic       rsh_q;
    logic       ctl_q;
    logic [7:0] key_q;
    logic       new_q;
    xlat_t      xl;
    logic [7:0] mapped;
    logic       is_mod;

    // Look up the byte and apply control and shift to letters.
    always_comb begin
        xl     = scan_lookup(byte_i);
        mapped = xl.ascii;
        if (xl.letter) begin
            if (ctl_q)              mapped = xl.ascii & 8'h1F;
            else if (lsh_q | rsh_q) mapped = xl.ascii - 8'h20;
        end
        is_mod = (byte_i == SC_LSHIFT) || (byte_i == SC_RSHIFT) ||
                 (byte_i == SC_CTRL);
    end

    // Update prefix, modifiers and held key for each received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_q <= 1'b0;
            lsh_q <= 1'b0;
            rsh_q <= 1'b0;
            ctl_q <= 1'b0;
            key_q <= 8'h00;
            new_q <= 1'b0;
        end else begin
            new_q <= 1'b0;
            if (byte_vld_i) begin
                if (byte_i == SC_BREAK) begin
                    brk_q <= 1'b1;
                end else begin
                    brk_q <= 1'b0;
                    if (byte_i == SC_LSHIFT)     lsh_q <= ~brk_q;
                    else if (byte_i == SC_RSHIFT) rsh_q <= ~brk_q;
                    else if (byte_i == SC_CTRL)   ctl_q <= ~brk_q;
                    else if (xl.hit) begin
                        if (brk_q) begin
                            key_q <= 8'h00;
                        end else begin
                            key_q <= mapped;
                            new_q <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign key_o = key_q;
    assign new_o = new_q;

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        new_q |=> !new_q);
    assert_strobe_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        new_q |-> key_q != 8'h00);
    assert_release_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && brk_q && xl.hit && !is_mod) |=> (key_q == 8'h00 && !new_q));
    assert_unknown_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld_i && !xl.hit && !is_mod && byte_i != SC_BREAK)
            |=> ($stable(key_q) && !new_q));

endmodule

// File: rtl/ps2_key_decoder.sv
// Module: ps2_key_decoder (top)
// Keyboard-to-host PS/2 receiver that presents the held key as ASCII.
// Assumes the keyboard clock is far slower than clk.
module ps2_key_decoder #(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 12500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic [7:0] key_code_o,
    output logic       key_new_o
);
    logic       clk_s;
    logic       dat_s;
    logic       fall;
    logic       byte_vld;
    logic [7:0] byte_rx;

    ps2kd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps2_clk_i (ps2_clk_i),
        .ps2_dat_i (ps2_dat_i),
        .clk_s_o   (clk_s),
        .dat_s_o   (dat_s),
        .fall_o    (fall)
    );

    ps2kd_framer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_s_i    (clk_s),
        .dat_s_i    (dat_s),
        .fall_i     (fall),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_rx)
    );

    ps2kd_keystate u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld),
        .byte_i     (byte_rx),
        .key_o      (key_code_o),
        .new_o      (key_new_o)
    );

endmodule

// File: tb/ps2_key_decoder_tb.sv
module ps2_key_decoder_tb;
    localparam int HALF = 40;
    localparam int TMO  = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic [7:0] key_code;
    logic       key_new;

    int n_checks = 0;
    int n_fail   = 0;
    int n_strobe = 0;
    bit done     = 1'b0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    ps2_key_decoder #(.TIMEOUT_CYC(TMO)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps2_clk_i  (ps2_clk),
        .ps2_dat_i  (ps2_dat),
        .key_code_o (key_code),
        .key_new_o  (key_new)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Monitor: pop the scoreboard on every strobe; also check pulse width (R3).
    logic prev_new = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (key_new) begin
                n_strobe++;
                check(!prev_new, "R3 strobe width", 8'(prev_new), 8'h00);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected strobe", key_code, 8'h00);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    check(key_code == e, "R2/R5/R6/R10 strobe value", key_code, e);
                end
            end
            prev_new = key_new;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ps2_bit(input logic b, input bit midchk, input logic [7:0] midexp);
        ps2_dat = b;
        wait_n(HALF);
        ps2_clk = 1'b0;
        if (midchk) begin
            wait_n(HALF / 2);
            check(key_code == midexp, "R11 key before parity", key_code, midexp);
            wait_n(HALF - HALF / 2);
        end else begin
            wait_n(HALF);
        end
        ps2_clk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit midchk,
                              input logic [7:0] midexp);
        ps2_bit(1'b0, 1'b0, 8'h00);
        for (int i = 0; i < 8; i++) ps2_bit(b[i], midchk && i == 7, midexp);
        ps2_bit(~^b, 1'b0, 8'h00);
        ps2_bit(1'b1, 1'b0, 8'h00);
        ps2_dat = 1'b1;
        wait_n(2 * HALF);
    endtask

    // Driver: push the expected ASCII, then send the make code.
    task automatic press(input logic [7:0] sc, input logic [7:0] asc, input string req);
        exp_q.push_back(asc);
        send_frame(sc, 1'b0, 8'h00);
        check(key_code == asc, req, key_code, asc);
    endtask

    task automatic release_key(input logic [7:0] sc);
        send_frame(8'hF0, 1'b0, 8'h00);
        send_frame(sc, 1'b0, 8'h00);
        check(key_code == 8'h00, "R4 release clears", key_code, 8'h00);
    endtask

    task automatic send_mod(input logic [7:0] sc, input bit brk);
        if (brk) send_frame(8'hF0, 1'b0, 8'h00);
        send_frame(sc, 1'b0, 8'h00);
    endtask

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        check(key_code == 8'h00, "R1 reset key", key_code, 8'h00);
        check(key_new == 1'b0, "R1 reset strobe", 8'(key_new), 8'h00);

        // R2 and R11: 'a' visible before the parity edge
        exp_q.push_back(8'h61);
        send_frame(8'h1C, 1'b1, 8'h61);
        check(key_code == 8'h61, "R2 make 0x1C", key_code, 8'h61);
        release_key(8'h1C);
        press(8'h32, 8'h62, "R2 make 0x32");
        release_key(8'h32);

        // R5: left shift, then right shift
        send_mod(8'h12, 1'b0);
        press(8'h1C, 8'h41, "R5 shifted a");
        release_key(8'h1C);
        send_mod(8'h12, 1'b1);
        press(8'h1C, 8'h61, "R5 shift released");
        release_key(8'h1C);
        send_mod(8'h59, 1'b0);
        press(8'h1A, 8'h5A, "R5 right shift z");
        press(8'h16, 8'h31, "R10 digit under shift");
        send_mod(8'h59, 1'b1);
        release_key(8'h16);

        // R6: control letter
        send_mod(8'h14, 1'b0);
        press(8'h21, 8'h03, "R6 ctrl c");
        release_key(8'h21);
        send_mod(8'h14, 1'b1);

        // R7: unknown code holds the register, no strobe
        press(8'h1C, 8'h61, "R7 setup");
        begin
            automatic int s0 = n_strobe;
            send_frame(8'h76, 1'b0, 8'h00);
            check(key_code == 8'h61, "R7 unknown hold", key_code, 8'h61);
            check(n_strobe == s0, "R7 no strobe", 8'(n_strobe - s0), 8'h00);
        end
        release_key(8'h1C);

        // R10: digit and enter
        press(8'h16, 8'h31, "R10 digit 1");
        press(8'h5A, 8'h0D, "R10 enter");
        release_key(8'h5A);

        // R8: stray edge with data high while idle
        ps2_bit(1'b1, 1'b0, 8'h00);
        wait_n(2 * HALF);
        press(8'h32, 8'h62, "R8 stray edge ignored");
        release_key(8'h32);

        // R9: stall mid-frame past the timeout
        ps2_bit(1'b0, 1'b0, 8'h00);
        ps2_bit(1'b1, 1'b0, 8'h00);
        ps2_bit(1'b0, 1'b0, 8'h00);
        ps2_dat = 1'b1;
        wait_n(TMO + 100);
        press(8'h24, 8'h65, "R9 frame after timeout");
        release_key(8'h24);

        wait_n(10);
        check(exp_q.size() == 0, "R3 all strobes seen", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule